// File: doc/BRIEF.md
# Open-Drain Multi-Channel Bus Repeater

This block is the digital core of a buffered switch that joins one upstream two-wire bus (a clock line and a data line) to a set of downstream channel pairs. Each physical open-drain line is modelled as two signals: a sensed level coming in, and a pull-low request going out. Pad logic outside the block turns a pull request into an open-drain driver. The sensed level is the wired-AND of every driver on that wire, including this block's own pull.

A separate register block supplies a per-channel enable vector and a clock-direction bit. In forward clock mode the upstream clock is fanned out to every enabled channel. In reverse mode, the enabled downstream clocks are wire-ANDed and driven upstream. The data path has no fixed direction. Whichever side pulls low first takes a lock and is repeated to the other side. The lock is held until that side lets its line rise again. This lets a master write, a slave acknowledge and a slave read-back pass through without a direction pin. All pull outputs are registered, so each one reflects the levels sampled at the previous clock edge.

Top module: `repeater_bus_switch`

## Requirements
- R1: A channel whose enable bit is 0 at a clock edge has both its clock pull and its data pull at 0 after that edge. Its sensed levels are excluded from every AND, so a low on a disabled channel starts no lock and produces no upstream pull.
- R2: With the direction bit at 0 (forward), after each edge every enabled channel's clock pull equals the inverse of the upstream clock level sampled at that edge, and the upstream clock pull is 0.
- R3: With the direction bit at 1 (reverse), after each edge the upstream clock pull is 1 exactly when some enabled channel's sensed clock was 0 at that edge, and every downstream clock pull is 0.
- R4: With no lock held, a low upstream data level sampled at an edge gives the upstream side the lock. After that edge the data pull of every enabled channel is 1 and the upstream data pull is 0.
- R5: With no lock held and the upstream data level high, a low wired-AND of the enabled downstream data levels gives the downstream side the lock. After that edge the upstream data pull is 1 and all downstream data pulls are 0.
- R6: A held lock stays with its owner while the owner's level is low, whatever the other side does. It is freed at the first edge where the owner's level is sampled high, and the pulls it caused drop at that same edge.
- R7: When both sides are first sampled low at the same edge with no lock held, the upstream side wins.
- R8: After a lock is freed, a low on the opposite side is taken over at the next edge. This is the direction reversal of an acknowledge or a read. No filtering or delay is applied, so the former input side sees the resulting low pulse.
- R9: While the active-low reset is asserted, all pull outputs are 0 and no lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | N_CH | Per-channel enable, 1 = channel connected |
| clk_rev | input | 1 | Clock direction: 0 upstream to channels, 1 channels to upstream |
| up_scl_lvl | input | 1 | Sensed upstream clock level |
| up_sda_lvl | input | 1 | Sensed upstream data level |
| dn_sc_lvl | input | N_CH | Sensed downstream clock levels |
| dn_sd_lvl | input | N_CH | Sensed downstream data levels |
| up_scl_pull | output | 1 | Pull-low request for the upstream clock |
| up_sda_pull | output | 1 | Pull-low request for the upstream data |
| dn_sc_pull | output | N_CH | Pull-low requests for the downstream clocks |
| dn_sd_pull | output | N_CH | Pull-low requests for the downstream data |

## Verification
The bench models every wire as the AND of an external driver and the block's own pull. This exposes self-latching: a design that treated its own pull as a new driver would never free a lock, and the read-back after an acknowledge would hang low. The bench runs a write, then a slave acknowledge where the lock flips direction. It also drives a downstream low while upstream owns the lock, and an upstream low while downstream owns it; a design without a real lock would swap owners mid-byte. A simultaneous low catches a wrong priority. A low on a disabled channel, in both the data path and the reverse clock path, catches an AND that forgets the enables. Dropping the enables during a held lock checks that the channel is released at once.

// File: rtl/bus_rep_pkg.sv
package bus_rep_pkg;
    typedef enum logic [1:0] {
        LOCK_FREE = 2'd0,
        LOCK_UP   = 2'd1,
        LOCK_DN   = 2'd2
    } lock_e;
endpackage

// File: rtl/rep_data_lock.sv
module rep_data_lock
    import bus_rep_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] en,
    input  logic            up_lvl,
    input  logic [N_CH-1:0] dn_lvl,
    output logic            up_pull,
    output logic [N_CH-1:0] dn_pull
);
    typedef struct packed {
        lock_e           lock;
        logic            up_pull;
        logic [N_CH-1:0] dn_pull;
    } dl_state_t;

    dl_state_t st_d, st_q;
    logic      dn_all_high;

    always_comb begin
        // disabled channels read as released
        dn_all_high = &(dn_lvl | ~en);
        st_d        = st_q;
        unique case (st_q.lock)
            LOCK_FREE: begin
                if (!up_lvl)          st_d.lock = LOCK_UP;
                else if (!dn_all_high) st_d.lock = LOCK_DN;
            end
            LOCK_UP:  if (up_lvl)      st_d.lock = LOCK_FREE;
            LOCK_DN:  if (dn_all_high) st_d.lock = LOCK_FREE;
            default:                   st_d.lock = LOCK_FREE;
        endcase
        st_d.up_pull = (st_d.lock == LOCK_DN);
        st_d.dn_pull = (st_d.lock == LOCK_UP) ? en : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lock: LOCK_FREE, up_pull: 1'b0, dn_pull: '0};
        else        st_q <= st_d;
    end

    assign up_pull = st_q.up_pull;
    assign dn_pull = st_q.dn_pull;

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_off_chan_data_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> ((dn_pull & ~$past(en)) == '0));
    assert_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_pull && (|dn_pull)));
    assert_dn_lock_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock == LOCK_DN && !dn_all_high) |=> (st_q.lock == LOCK_DN));
    assert_upstream_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock == LOCK_FREE && !up_lvl) |=> (st_q.lock == LOCK_UP));
endmodule

// File: rtl/rep_clk_steer.sv
module rep_clk_steer #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rev,
    input  logic [N_CH-1:0] en,
    input  logic            up_lvl,
    input  logic [N_CH-1:0] dn_lvl,
    output logic            up_pull,
    output logic [N_CH-1:0] dn_pull
);
    typedef struct packed {
        logic            up_pull;
        logic [N_CH-1:0] dn_pull;
    } cs_state_t;

    cs_state_t       st_d, st_q;
    logic [N_CH-1:0] fwd_pull;
    logic [N_CH-1:0] chan_low;

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_chan
        assign fwd_pull[gi] = en[gi] & ~up_lvl;
        assign chan_low[gi] = en[gi] & ~dn_lvl[gi];
    end

    always_comb begin
        st_d = st_q;
        if (rev) begin
            st_d.up_pull = |chan_low;
            st_d.dn_pull = '0;
        end else begin
            st_d.up_pull = 1'b0;
            st_d.dn_pull = fwd_pull;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_pull = st_q.up_pull;
    assign dn_pull = st_q.dn_pull;

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_off_chan_clk_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> ((dn_pull & ~$past(en)) == '0));
    assert_fwd_no_up_pull_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(rev)) |-> !up_pull);
    assert_rev_no_dn_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(rev)) |-> (dn_pull == '0));
endmodule

// File: rtl/repeater_bus_switch.sv
module repeater_bus_switch #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_en,
    input  logic            clk_rev,
    input  logic            up_scl_lvl,
    input  logic            up_sda_lvl,
    input  logic [N_CH-1:0] dn_sc_lvl,
    input  logic [N_CH-1:0] dn_sd_lvl,
    output logic            up_scl_pull,
    output logic            up_sda_pull,
    output logic [N_CH-1:0] dn_sc_pull,
    output logic [N_CH-1:0] dn_sd_pull
);
    rep_clk_steer #(.N_CH(N_CH)) i_clk_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rev     (clk_rev),
        .en      (chan_en),
        .up_lvl  (up_scl_lvl),
        .dn_lvl  (dn_sc_lvl),
        .up_pull (up_scl_pull),
        .dn_pull (dn_sc_pull)
    );

    rep_data_lock #(.N_CH(N_CH)) i_data_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (chan_en),
        .up_lvl  (up_sda_lvl),
        .dn_lvl  (dn_sd_lvl),
        .up_pull (up_sda_pull),
        .dn_pull (dn_sd_pull)
    );

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> (!up_scl_pull && !up_sda_pull && dn_sc_pull == '0 && dn_sd_pull == '0));
endmodule

// File: tb/test_repeater_bus_switch.sv
module test_repeater_bus_switch;
    localparam int N  = 4;
    localparam int OW = 2 + 2 * N;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0] en_r, xsc, xsd;
    logic rev_r, xscl, xsda;
    logic up_scl_pull, up_sda_pull;
    logic [N-1:0] dn_sc_pull, dn_sd_pull;
    logic up_scl_lvl, up_sda_lvl;
    logic [N-1:0] dn_sc_lvl, dn_sd_lvl;

    always #10 clk = ~clk;

    // wires: AND of external driver and the block's own pull
    assign up_scl_lvl = xscl & ~up_scl_pull;
    assign up_sda_lvl = xsda & ~up_sda_pull;
    assign dn_sc_lvl  = xsc & ~dn_sc_pull;
    assign dn_sd_lvl  = xsd & ~dn_sd_pull;

    repeater_bus_switch #(.N_CH(N)) i_repeater_bus_switch (
        .clk(clk), .rst_n(rst_n), .chan_en(en_r), .clk_rev(rev_r),
        .up_scl_lvl(up_scl_lvl), .up_sda_lvl(up_sda_lvl),
        .dn_sc_lvl(dn_sc_lvl), .dn_sd_lvl(dn_sd_lvl),
        .up_scl_pull(up_scl_pull), .up_sda_pull(up_sda_pull),
        .dn_sc_pull(dn_sc_pull), .dn_sd_pull(dn_sd_pull)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    logic [OW-1:0] exp_q[$];
    string         tag_q[$];

    // reference: 0 free, 1 upstream owns, 2 downstream owns
    int m_lock = 0;
    logic m_up_scl = 0, m_up_sda = 0;
    logic [N-1:0] m_dn_sc = '0, m_dn_sd = '0;

    function automatic logic [OW-1:0] outs_now();
        return {up_scl_pull, up_sda_pull, dn_sc_pull, dn_sd_pull};
    endfunction

    task automatic compare(input logic [OW-1:0] exp, input string tag);
        logic [OW-1:0] act = outs_now();
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] e, input logic d, input logic s_cl,
                        input logic s_da, input logic [N-1:0] c_dn,
                        input logic [N-1:0] d_dn, input string tag);
        logic l_scl, l_sda, dn_hi, any_sc_low;
        logic [N-1:0] l_sc, l_sd;
        @(negedge clk);
        en_r = e; rev_r = d; xscl = s_cl; xsda = s_da; xsc = c_dn; xsd = d_dn;
        l_scl = s_cl & ~m_up_scl;
        l_sda = s_da & ~m_up_sda;
        l_sc  = c_dn & ~m_dn_sc;
        l_sd  = d_dn & ~m_dn_sd;
        dn_hi = &(l_sd | ~e);
        any_sc_low = |(e & ~l_sc);
        case (m_lock)
            0: if (!l_sda) m_lock = 1; else if (!dn_hi) m_lock = 2;
            1: if (l_sda) m_lock = 0;
            default: if (dn_hi) m_lock = 0;
        endcase
        m_up_sda = (m_lock == 2);
        m_dn_sd  = (m_lock == 1) ? e : '0;
        if (d) begin m_up_scl = any_sc_low; m_dn_sc = '0; end
        else   begin m_up_scl = 1'b0; m_dn_sc = e & {N{~l_scl}}; end
        exp_q.push_back({m_up_scl, m_up_sda, m_dn_sc, m_dn_sd});
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expectation per edge, samples mid high phase
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst_n = 0; en_r = '1; rev_r = 0; xscl = 0; xsda = 0; xsc = '0; xsd = '0;
        repeat (3) @(posedge clk);
        #5 compare('0, "R9 outputs quiet in reset");
        @(negedge clk);
        en_r = '0; xscl = 1; xsda = 1; xsc = '1; xsd = '1;
        rst_n = 1;
        // forward clock, channels 3 and 1 enabled
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1111, "R9 idle after reset");
        step(4'b1010, 0, 0, 1, 4'b1111, 4'b1111, "R2 clock low fanned out, R1 off channels");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1111, "R2 clock high released");
        step(4'b1010, 0, 0, 1, 4'b1111, 4'b1111, "R2 clock low again");
        // write: master drives data low
        step(4'b1010, 0, 1, 0, 4'b1111, 4'b1111, "R4 upstream takes lock");
        step(4'b1010, 0, 1, 0, 4'b1111, 4'b1101, "R6 downstream low ignored under upstream lock");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1101, "R6 upstream release frees lock");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1101, "R8 slave ack taken over at once");
        step(4'b1010, 0, 0, 1, 4'b1111, 4'b1101, "R5 downstream owns, upstream pulled");
        step(4'b1010, 0, 0, 0, 4'b1111, 4'b1101, "R6 upstream low ignored under downstream lock");
        step(4'b1010, 0, 1, 0, 4'b1111, 4'b1111, "R6 downstream release frees lock");
        step(4'b1010, 0, 1, 0, 4'b1111, 4'b1111, "R8 upstream read-back takeover");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1111, "R6 release after read-back");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1111, "R6 idle with both high");
        // simultaneous lows
        step(4'b1010, 0, 1, 0, 4'b1111, 4'b0111, "R7 simultaneous low, upstream wins");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1111, "R7 release");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1111, "R7 idle");
        // disabled channel data low
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1110, "R1 disabled data channel starts no lock");
        step(4'b1010, 0, 1, 1, 4'b1111, 4'b1111, "R1 idle");
        // reverse clock, channels 2 and 1 enabled
        step(4'b0110, 1, 1, 1, 4'b1111, 4'b1111, "R3 reverse idle");
        step(4'b0110, 1, 1, 1, 4'b1110, 4'b1111, "R3 disabled clock excluded from AND");
        step(4'b0110, 1, 1, 1, 4'b1011, 4'b1111, "R3 enabled clock low pulls upstream");
        step(4'b0110, 1, 1, 1, 4'b1001, 4'b1111, "R3 two enabled clocks low");
        step(4'b0110, 1, 1, 1, 4'b1111, 4'b1111, "R3 all released");
        step(4'b0000, 1, 1, 1, 4'b0000, 4'b1111, "R3 nothing enabled reads high");
        // enables cleared while upstream holds the lock
        step(4'b1111, 0, 1, 0, 4'b1111, 4'b1111, "R4 lock on all channels");
        step(4'b0000, 0, 1, 0, 4'b1111, 4'b1111, "R1 cleared enables release held channels");
        step(4'b0000, 0, 1, 1, 4'b1111, 4'b1111, "R6 release with no channels");
        step(4'b0000, 0, 1, 1, 4'b1111, 4'b1111, "R1 all quiet");
        repeat (3) @(posedge clk);
        #10;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule